// File: doc/BRIEF.md
# Memory Access Address Checker

This block sits in the path from a processor's load, store and fetch stage to memory. Each request carries an address, a size, an access kind and the core variant whose rules apply. The block returns the address with its low bits cleared to the access size, and six fault flags. The flags report misalignment and hits on fixed reserved address windows, and which flag a request raises depends on the variant, the kind, the size and two control bits.

The two variants report faults differently. On variant A, a misaligned data access is a data access error, and the alignment-exception mask bit can suppress it. Variant A also checks the upper window for double-word data accesses only. On variant B, any misaligned access gets its own not-aligned flag. Variant B also has separate error and exception windows, and one small window is blocked for fetches only while reserved memory is disabled.

The result is registered and appears one clock after the request, with a result-valid strobe. A small two-state machine tracks whether a result is on the outputs. `ST_IDLE` moves to `ST_REPORT` on a valid request (transition *accept*). `ST_REPORT` stays in `ST_REPORT` on a back-to-back request (*accept*) and returns to `ST_IDLE` when no request is valid (*drain*). Reset forces `ST_IDLE`.

Top module: `mem_addr_checker`

## Requirements
- R1: While `rst_n` is low at a clock edge (synchronous, active low), the state goes to `ST_IDLE`, and `rsp_valid`, `rsp_addr` and all six fault flags are 0 after that edge, whatever the request inputs are.
- R2: Each result appears on the clock edge after its request, with `rsp_valid` = 1. After an edge where `req_valid` was 0, `rsp_valid`, `rsp_addr` and all flags are 0.
- R3: `req_size` codes 0,1,2,3,4 mean 1,2,4,8,16 bytes, and codes 5 to 7 are treated as 16 bytes. The access is misaligned if any address bit below the size is set. `rsp_addr` always has those bits cleared, and all window checks use this cleared address.
- R4: Variant A (`req_core`=0), kind load (0) or store (1): misalignment sets `flt_dacc_err` only when `align_exc_mask` is 0. Variant A never sets `flt_misalign`.
- R5: Variant A, load of 8 bytes (size code 3) to 0xFE800000..0xFEFFFFFF sets `flt_dacc_err`. Loads of other sizes to that window raise nothing from the window.
- R6: Variant A, store of 8 bytes to 0xFE800000..0xFEFFFFFF sets `flt_store_err`. Stores of other sizes there do not.
- R7: Variant A, fetch (kind 2): misalignment, or an address in 0xFE800000..0xFEFFFFFF, sets `flt_iacc_err`.
- R8: Variant B (`req_core`=1): misalignment sets `flt_misalign` for load, store and fetch.
- R9: Variant B, an address in 0xFEFF0600..0xFEFF7FFF or in 0xFE800000..0xFEFEFFFF sets `flt_dacc_err` for a load and `flt_store_err` for a store, for any size.
- R10: Variant B, a load or store to 0xFE000000..0xFE7FFFFF sets `flt_dacc_exc`, for any size.
- R11: Variant B, fetch: the two R9 windows set `flt_iacc_err`. 0xFE004000..0xFE7FFFFF sets `flt_iacc_exc`. 0xFE000000..0xFE003FFF sets `flt_iacc_exc` only when `resv_mem_en` is 0. A fetch never sets a data-side flag.
- R12: Kind code 3 is a no-op: the aligned address is returned with `rsp_valid` = 1 and no fault flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Request address |
| req_size | input | SIZE_W | Size code (log2 of bytes) |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch, 3 none |
| req_core | input | 1 | 0 variant A, 1 variant B |
| align_exc_mask | input | 1 | Suppresses variant A misalignment error |
| resv_mem_en | input | 1 | Reserved memory enabled (opens the small fetch window) |
| rsp_valid | output | 1 | Result valid strobe |
| rsp_addr | output | ADDR_W | Address with the low bits cleared to the size |
| flt_misalign | output | 1 | Not-aligned fault |
| flt_dacc_err | output | 1 | Data access error |
| flt_dacc_exc | output | 1 | Data access exception |
| flt_iacc_err | output | 1 | Instruction access error |
| flt_iacc_exc | output | 1 | Instruction access exception |
| flt_store_err | output | 1 | Data store error |

## Verification
Every output is due exactly one rising edge after the request that caused it. The inputs for the next request change at that same edge, so each result is valid for one full cycle. The bench drives each request on a falling edge and computes the expected result from the requirements at that moment. It compares the outputs on the next falling edge, which is the first sampling point after the register loads. Idle cycles are compared the same way, and the reset check runs on the falling edges while reset is held.

// File: rtl/addr_chk_pkg.sv
package addr_chk_pkg;

    typedef enum logic {
        CORE_A = 1'b0,
        CORE_B = 1'b1
    } core_e;

    typedef enum logic [1:0] {
        K_LOAD  = 2'd0,
        K_STORE = 2'd1,
        K_FETCH = 2'd2,
        K_NONE  = 2'd3
    } kind_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } rsp_state_e;

    typedef struct packed {
        logic misalign;
        logic dacc_err;
        logic dacc_exc;
        logic iacc_err;
        logic iacc_exc;
        logic store_err;
    } fault_t;

    // Size code of a double-word access; some window checks apply to it only
    localparam int SZ_DWORD = 3;

    // Window indices
    localparam int NUM_WIN     = 6;
    localparam int W_UPPER     = 0; // variant A error window
    localparam int W_SLICE     = 1; // variant B error window, small
    localparam int W_BULK      = 2; // variant B error window, large
    localparam int W_EXC_ALL   = 3; // variant B data exception window
    localparam int W_EXC_HIGH  = 4; // variant B fetch exception window
    localparam int W_RESV      = 5; // reserved block, fetch blocked unless enabled

    localparam logic [31:0] WIN_LO [NUM_WIN] = '{
        32'hFE80_0000, 32'hFEFF_0600, 32'hFE80_0000,
        32'hFE00_0000, 32'hFE00_4000, 32'hFE00_0000
    };
    localparam logic [31:0] WIN_HI [NUM_WIN] = '{
        32'hFEFF_FFFF, 32'hFEFF_7FFF, 32'hFEFE_FFFF,
        32'hFE7F_FFFF, 32'hFE7F_FFFF, 32'hFE00_3FFF
    };

endpackage

// File: rtl/addr_aligner.sv
module addr_aligner #(
    parameter int ADDR_W        = 32,
    parameter int SIZE_W        = 3,
    parameter int MAX_ALIGN_LOG = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size,
    output logic [ADDR_W-1:0] aligned,
    output logic              misaligned
);
    localparam int HI_W = ADDR_W - MAX_ALIGN_LOG;

    logic [MAX_ALIGN_LOG-1:0] low_mask;

    // Bit i of the mask is set when the access spans more than 2**i bytes;
    // codes past the largest size saturate to the full mask.
    generate
        for (genvar i = 0; i < MAX_ALIGN_LOG; i++) begin : g_mask
            assign low_mask[i] = (size > SIZE_W'(i));
        end
    endgenerate

    assign aligned    = {addr[ADDR_W-1:MAX_ALIGN_LOG],
                         addr[MAX_ALIGN_LOG-1:0] & ~low_mask};
    assign misaligned = |(addr[MAX_ALIGN_LOG-1:0] & low_mask);

    logic [HI_W-1:0] unused_hi;
    assign unused_hi = addr[ADDR_W-1:MAX_ALIGN_LOG];

endmodule

// File: rtl/addr_window_match.sv
module addr_window_match #(
    parameter int          ADDR_W = 32,
    parameter logic [31:0] LO     = 32'h0,
    parameter logic [31:0] HI     = 32'h0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam logic [ADDR_W-1:0] LO_X = ADDR_W'(LO);
    localparam logic [ADDR_W-1:0] HI_X = ADDR_W'(HI);

    assign hit = (addr >= LO_X) && (addr <= HI_X);
endmodule

// File: rtl/window_decoder.sv
module window_decoder
    import addr_chk_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic [NUM_WIN-1:0] hits
);
    generate
        for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
            addr_window_match #(
                .ADDR_W (ADDR_W),
                .LO     (WIN_LO[w]),
                .HI     (WIN_HI[w])
            ) u_match (
                .addr (addr),
                .hit  (hits[w])
            );
        end
    endgenerate
endmodule

// File: rtl/fault_rules.sv
module fault_rules
    import addr_chk_pkg::*;
#(
    parameter int SIZE_W = 3
) (
    input  core_e              core,
    input  kind_e              kind,
    input  logic [SIZE_W-1:0]  size,
    input  logic               misaligned,
    input  logic [NUM_WIN-1:0] hits,
    input  logic               align_exc_mask,
    input  logic               resv_mem_en,
    output fault_t             faults
);
    logic is_dw;
    logic b_err_win;
    logic a_mis_err;

    assign is_dw     = (size == SIZE_W'(SZ_DWORD));
    assign b_err_win = hits[W_SLICE] | hits[W_BULK];
    assign a_mis_err = misaligned & ~align_exc_mask;

    always_comb begin
        faults = '0;
        unique case (core)
            CORE_A: begin
                unique case (kind)
                    K_LOAD: begin
                        faults.dacc_err  = a_mis_err | (is_dw & hits[W_UPPER]);
                    end
                    K_STORE: begin
                        faults.dacc_err  = a_mis_err;
                        faults.store_err = is_dw & hits[W_UPPER];
                    end
                    K_FETCH: begin
                        faults.iacc_err  = misaligned | hits[W_UPPER];
                    end
                    K_NONE: ;
                endcase
            end
            CORE_B: begin
                unique case (kind)
                    K_LOAD: begin
                        faults.misalign  = misaligned;
                        faults.dacc_err  = b_err_win;
                        faults.dacc_exc  = hits[W_EXC_ALL];
                    end
                    K_STORE: begin
                        faults.misalign  = misaligned;
                        faults.store_err = b_err_win;
                        faults.dacc_exc  = hits[W_EXC_ALL];
                    end
                    K_FETCH: begin
                        faults.misalign  = misaligned;
                        faults.iacc_err  = b_err_win;
                        faults.iacc_exc  = ~b_err_win &
                                           (hits[W_EXC_HIGH] | (~resv_mem_en & hits[W_RESV]));
                    end
                    K_NONE: ;
                endcase
            end
        endcase
    end
endmodule

// File: rtl/mem_addr_checker.sv
module mem_addr_checker
    import addr_chk_pkg::*;
#(
    parameter int ADDR_W        = 32,
    parameter int SIZE_W        = 3,
    parameter int MAX_ALIGN_LOG = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [1:0]        req_kind,
    input  logic              req_core,
    input  logic              align_exc_mask,
    input  logic              resv_mem_en,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic              flt_misalign,
    output logic              flt_dacc_err,
    output logic              flt_dacc_exc,
    output logic              flt_iacc_err,
    output logic              flt_iacc_exc,
    output logic              flt_store_err
);
    logic [ADDR_W-1:0]  aligned;
    logic               misaligned;
    logic [NUM_WIN-1:0] hits;
    fault_t             faults;
    fault_t             faults_q;
    rsp_state_e         state_q;
    rsp_state_e         state_d;

    addr_aligner #(
        .ADDR_W        (ADDR_W),
        .SIZE_W        (SIZE_W),
        .MAX_ALIGN_LOG (MAX_ALIGN_LOG)
    ) u_align (
        .addr       (req_addr),
        .size       (req_size),
        .aligned    (aligned),
        .misaligned (misaligned)
    );

    window_decoder #(
        .ADDR_W (ADDR_W)
    ) u_win (
        .addr (aligned),
        .hits (hits)
    );

    fault_rules #(
        .SIZE_W (SIZE_W)
    ) u_rules (
        .core           (core_e'(req_core)),
        .kind           (kind_e'(req_kind)),
        .size           (req_size),
        .misaligned     (misaligned),
        .hits           (hits),
        .align_exc_mask (align_exc_mask),
        .resv_mem_en    (resv_mem_en),
        .faults         (faults)
    );

    // Next-state: accept on a valid request, drain otherwise
    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = req_valid ? ST_REPORT : ST_IDLE;
            ST_REPORT: state_d = req_valid ? ST_REPORT : ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n || !req_valid) begin
            rsp_addr <= '0;
            faults_q <= '0;
        end else begin
            rsp_addr <= aligned;
            faults_q <= faults;
        end
    end

    assign rsp_valid     = (state_q == ST_REPORT);
    assign flt_misalign  = faults_q.misalign;
    assign flt_dacc_err  = faults_q.dacc_err;
    assign flt_dacc_exc  = faults_q.dacc_exc;
    assign flt_iacc_err  = faults_q.iacc_err;
    assign flt_iacc_exc  = faults_q.iacc_exc;
    assign flt_store_err = faults_q.store_err;

    // ---------------- assertions ----------------
    p_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && rsp_addr == '0 &&
                        !flt_misalign && !flt_dacc_err && !flt_dacc_exc &&
                        !flt_iacc_err && !flt_iacc_exc && !flt_store_err));

    p_word_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == SIZE_W'(2)) |=> (rsp_addr[1:0] == 2'b00));

    p_a_no_misalign_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_core == 1'b0) |=> !flt_misalign);

    p_load_no_store_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd0) |=> (!flt_store_err && !flt_iacc_err && !flt_iacc_exc));

    p_fetch_no_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd2) |=> (!flt_dacc_err && !flt_dacc_exc && !flt_store_err));

    p_resv_open_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_core == 1'b1 && req_kind == 2'd2 && resv_mem_en &&
         req_addr >= ADDR_W'(32'hFE00_0000) && req_addr <= ADDR_W'(32'hFE00_3FFF))
        |=> !flt_iacc_exc);

    p_none_clean_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd3) |=> (!flt_misalign && !flt_dacc_err && !flt_dacc_exc &&
                                             !flt_iacc_err && !flt_iacc_exc && !flt_store_err));

endmodule

// File: tb/test_mem_addr_checker.sv
module test_mem_addr_checker;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [31:0] req_addr;
    logic [2:0]  req_size;
    logic [1:0]  req_kind;
    logic        req_core;
    logic        align_exc_mask;
    logic        resv_mem_en;
    logic        rsp_valid;
    logic [31:0] rsp_addr;
    logic        flt_misalign, flt_dacc_err, flt_dacc_exc;
    logic        flt_iacc_err, flt_iacc_exc, flt_store_err;

    int tests_run = 0;
    int tests_failed = 0;

    logic [38:0] exp_vec;
    string       exp_tag;
    bit          have_exp = 0;

    always #2 clk = ~clk;   // 250 MHz

    mem_addr_checker i_mem_addr_checker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_kind(req_kind), .req_core(req_core),
        .align_exc_mask(align_exc_mask), .resv_mem_en(resv_mem_en),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
        .flt_misalign(flt_misalign), .flt_dacc_err(flt_dacc_err),
        .flt_dacc_exc(flt_dacc_exc), .flt_iacc_err(flt_iacc_err),
        .flt_iacc_exc(flt_iacc_exc), .flt_store_err(flt_store_err)
    );

    function automatic bit inr(logic [31:0] a, logic [31:0] lo, logic [31:0] hi);
        return (a >= lo) && (a <= hi);
    endfunction

    // Reference: {valid, addr, misalign, dacc_err, dacc_exc, iacc_err, iacc_exc, store_err}
    function automatic logic [38:0] ref_result(bit v, logic [31:0] a, int sz, int kind,
                                               int core, bit msk, bit resv);
        logic [31:0] m, al;
        bit mis, e_up, e_b, x_all, x_hi, x_rs;
        bit f_mis = 0, f_de = 0, f_dx = 0, f_ie = 0, f_ix = 0, f_se = 0;
        if (!v) return '0;
        m     = (sz > 4) ? 32'd15 : (32'd1 << sz) - 32'd1;
        al    = a & ~m;
        mis   = (a & m) != 0;
        e_up  = inr(al, 32'hFE800000, 32'hFEFFFFFF);
        e_b   = inr(al, 32'hFEFF0600, 32'hFEFF7FFF) || inr(al, 32'hFE800000, 32'hFEFEFFFF);
        x_all = inr(al, 32'hFE000000, 32'hFE7FFFFF);
        x_hi  = inr(al, 32'hFE004000, 32'hFE7FFFFF);
        x_rs  = inr(al, 32'hFE000000, 32'hFE003FFF);
        if (core == 0) begin
            if (kind == 0) f_de = (mis && !msk) || (sz == 3 && e_up);
            if (kind == 1) begin f_de = mis && !msk; f_se = (sz == 3 && e_up); end
            if (kind == 2) f_ie = mis || e_up;
        end else if (kind != 3) begin
            f_mis = mis;
            if (kind == 0) begin f_de = e_b; f_dx = x_all; end
            if (kind == 1) begin f_se = e_b; f_dx = x_all; end
            if (kind == 2) begin
                if (e_b) f_ie = 1;
                else if (x_hi || (!resv && x_rs)) f_ix = 1;
            end
        end
        return {1'b1, al, f_mis, f_de, f_dx, f_ie, f_ix, f_se};
    endfunction

    function automatic logic [38:0] actual();
        return {rsp_valid, rsp_addr, flt_misalign, flt_dacc_err, flt_dacc_exc,
                flt_iacc_err, flt_iacc_exc, flt_store_err};
    endfunction

    task automatic check(string tag, logic [38:0] exp);
        tests_run++;
        if (actual() !== exp) begin
            tests_failed++;
            $display("FAIL %s actual=%h expected=%h", tag, actual(), exp);
        end
    endtask

    // Compare the previous request's result, then drive the next request
    task automatic step(string tag, bit v, logic [31:0] a, int sz, int kind,
                        int core, bit msk, bit resv);
        @(negedge clk);
        if (have_exp) check(exp_tag, exp_vec);
        req_valid      = v;
        req_addr       = a;
        req_size       = 3'(sz);
        req_kind       = 2'(kind);
        req_core       = core[0];
        align_exc_mask = msk;
        resv_mem_en    = resv;
        exp_vec  = ref_result(v, a, sz, kind, core, msk, resv);
        exp_tag  = tag;
        have_exp = 1;
    endtask

    initial begin
        #(4 * 200000);
        tests_failed++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        rst_n = 0; req_valid = 1; req_addr = 32'hFE800001; req_size = 3;
        req_kind = 0; req_core = 0; align_exc_mask = 0; resv_mem_en = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", '0);
        @(negedge clk);
        check("R1", '0);
        rst_n = 1; req_valid = 0;
        exp_vec = '0; exp_tag = "R2"; have_exp = 1;

        // R3: size decode and address clearing
        step("R3", 1, 32'h00001007, 2, 0, 1, 0, 0);
        step("R3", 1, 32'h0000101F, 4, 0, 1, 0, 0);
        step("R3", 1, 32'h0000102F, 6, 1, 1, 0, 0);
        step("R3", 1, 32'h00000013, 0, 0, 1, 0, 0);
        step("R3", 1, 32'h00000016, 1, 0, 1, 0, 0);
        step("R2", 0, 32'hFE800000, 3, 0, 0, 0, 0);
        // R4: variant A misalignment and mask
        step("R4", 1, 32'h00000102, 2, 0, 0, 0, 0);
        step("R4", 1, 32'h00000102, 2, 0, 0, 1, 0);
        step("R4", 1, 32'h00000101, 1, 1, 0, 0, 0);
        step("R4", 1, 32'h00000101, 1, 1, 0, 1, 0);
        // R5: variant A double-word load window
        step("R5", 1, 32'hFE800000, 3, 0, 0, 0, 0);
        step("R5", 1, 32'hFE800000, 2, 0, 0, 0, 0);
        step("R5", 1, 32'hFE7FFFF8, 3, 0, 0, 0, 0);
        step("R5", 1, 32'hFEFFFFF8, 3, 0, 0, 0, 0);
        step("R5", 1, 32'hFF000000, 3, 0, 0, 0, 0);
        step("R5", 1, 32'hFE800000, 4, 0, 0, 0, 0);
        // R6: variant A double-word store window
        step("R6", 1, 32'hFE900000, 3, 1, 0, 0, 0);
        step("R6", 1, 32'hFE900000, 4, 1, 0, 0, 0);
        step("R6", 1, 32'hFE900004, 3, 1, 0, 1, 0);
        // R7: variant A fetch
        step("R7", 1, 32'h00000102, 2, 2, 0, 0, 0);
        step("R7", 1, 32'h00000102, 2, 2, 0, 1, 0);
        step("R7", 1, 32'hFE800000, 2, 2, 0, 0, 0);
        step("R7", 1, 32'hFE7FFFFC, 2, 2, 0, 0, 0);
        step("R2", 0, 32'h0, 0, 0, 0, 0, 0);
        // R8: variant B not-aligned for every kind
        step("R8", 1, 32'h00000006, 2, 1, 1, 1, 0);
        step("R8", 1, 32'h00000002, 2, 2, 1, 0, 0);
        step("R8", 1, 32'h00000004, 3, 0, 1, 0, 0);
        // R9: variant B error windows
        step("R9", 1, 32'hFEFF0600, 2, 0, 1, 0, 0);
        step("R9", 1, 32'hFEFF05FC, 2, 0, 1, 0, 0);
        step("R9", 1, 32'hFEFF8000, 2, 0, 1, 0, 0);
        step("R9", 1, 32'hFEFEFFFC, 2, 0, 1, 0, 0);
        step("R9", 1, 32'hFEFF7FFF, 0, 1, 1, 0, 0);
        step("R9", 1, 32'hFE800003, 3, 1, 1, 0, 0);
        // R10: variant B data exception window
        step("R10", 1, 32'hFE000000, 0, 0, 1, 0, 0);
        step("R10", 1, 32'hFE7FFFFF, 0, 1, 1, 0, 0);
        step("R10", 1, 32'hFDFFFFFF, 0, 0, 1, 0, 0);
        step("R10", 1, 32'hFE800000, 0, 0, 1, 0, 0);
        // R11: variant B fetch
        step("R11", 1, 32'hFE003FFC, 2, 2, 1, 0, 0);
        step("R11", 1, 32'hFE003FFC, 2, 2, 1, 0, 1);
        step("R11", 1, 32'hFE004000, 2, 2, 1, 0, 1);
        step("R11", 1, 32'hFEFF0600, 2, 2, 1, 0, 0);
        step("R11", 1, 32'hFE7FFFFC, 2, 2, 1, 0, 0);
        step("R11", 1, 32'hFE000001, 2, 2, 1, 0, 1);
        // R12: no-op kind
        step("R12", 1, 32'hFE800005, 2, 3, 1, 0, 0);
        step("R12", 1, 32'hFE800005, 3, 3, 0, 0, 0);
        step("R2", 0, 32'h0, 0, 0, 0, 0, 0);
        step("R2", 0, 32'h0, 0, 0, 0, 0, 0);

        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end
endmodule